// File: doc/BRIEF.md
# Microcoded Control Unit with Field Decoders

This block sequences a small 8-bit accumulator machine. A 4-bit step counter and the class bits of the current opcode address a microcode store that is computed by a synthesizable function. Each microcode word carries three packed 3-bit codes: which register drives the bus, which register is loaded from it, and one control action. Each code is expanded into enables by its own decoder, so one step moves at most one value and performs at most one action. Operations too long for 16 steps are written as two consecutive opcodes.

Two opcode bits bypass the store. Bit 0 drives the adder's invert line directly, so neighbouring opcodes share one program and differ only in add or subtract. Bit 7 redirects every accumulator reference in the program to the alternate register C for the whole instruction, so A and C are never both addressed by one opcode. Opcode bits 6:1 form the class that selects the program.

Top module: `ctl_unit`

## Requirements
- R1: A synchronous active-high reset forces the step to 0; in step 0 every opcode moves PC to MAR (src_en bit 4, dst_en bit 4) with no control action.
- R2: In step 1 every opcode moves MEM to IR (src_en bit 5, dst_en bit 6) and asserts ce.
- R3: src_en is zero or one-hot in every cycle; bits are [0] A, [1] B, [2] C, [3] scratch T, [4] PC, [5] MEM, [6] SUM.
- R4: dst_en is zero or one-hot in every cycle; bits are [0] A, [1] B, [2] C, [3] scratch T, [4] MAR, [5] MEM, [6] IR, [7] OUT.
- R5: With ir[7]=1 each accumulator reference enables C and never A; with ir[7]=0 it enables A and never C.
- R6: alu_inv equals ir[0] in every step.
- R7: A step holding the end action returns the step to 0 at the next edge, while the transfer in that same step is still driven.
- R8: Opcodes of class 8 or above idle in steps 2 to 15 and the step wraps from 15 to 0.
- R9: sum_pc is driven by the jump action unconditionally, by the zero-branch action only when flags[0]=1, and by the carry-branch action only when flags[1]=1; ce and sum_pc never coincide.
- R10: Class 1: step 2 PC to MAR; step 3 MEM to B with ce; step 4 SUM to T with flags_ld; step 5 T to accumulator and end. Class 2: step 2 PC to MAR; step 3 MEM to accumulator with ce; step 4 end.
- R11: Classes 3, 4 and 5: step 2 PC to MAR; step 3 MEM to B with ce; step 4 jump, zero-branch or carry-branch action respectively; step 5 end.
- R12: Class 0: step 2 end. Class 6: step 2 accumulator to OUT and end. Class 7: step 2 accumulator to T; step 3 T to B and end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 8 | Instruction register: [7] swap, [6:1] class, [0] invert |
| flags | input | 2 | [0] zero, [1] carry |
| step_o | output | 4 | Current microstep |
| src_en | output | 7 | One-hot bus source enables |
| dst_en | output | 8 | One-hot bus destination enables |
| ce | output | 1 | Increment MAR and PC together |
| sum_pc | output | 1 | Load adder result into PC |
| flags_ld | output | 1 | Capture flags |
| alu_inv | output | 1 | Adder invert (subtract) |

## Verification
The early end and a register transfer fall in the same microstep in the ALU, output and move programs, and the swap bit acts on that very transfer. The bench runs these opcodes with both swap settings and both invert settings, checks that the accumulator or C load is still driven while the end is taken, and then checks that the next cycle shows step 0 with the fetch transfer. Branch steps are driven with random flag values so the gating of sum_pc is judged against both the taken and the untaken case.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int P_OPC_W  = 8;
    localparam int P_STEP_W = 4;
    localparam int P_CLS_W  = P_OPC_W - 2;
    localparam int P_CODE_W = 3;
    localparam int N_SRC    = 7;
    localparam int N_DST    = 8;

    typedef enum logic [P_CODE_W-1:0] {
        SRC_NONE = 3'd0, SRC_ACC = 3'd1, SRC_B = 3'd2, SRC_TMP = 3'd3,
        SRC_PC = 3'd4, SRC_MEM = 3'd5, SRC_SUM = 3'd6
    } src_e;

    typedef enum logic [P_CODE_W-1:0] {
        DST_NONE = 3'd0, DST_ACC = 3'd1, DST_B = 3'd2, DST_TMP = 3'd3,
        DST_MAR = 3'd4, DST_MEM = 3'd5, DST_IR = 3'd6, DST_OUT = 3'd7
    } dst_e;

    typedef enum logic [P_CODE_W-1:0] {
        CTL_NONE = 3'd0, CTL_CE = 3'd1, CTL_SUMPC = 3'd2, CTL_FLAGS = 3'd3,
        CTL_END = 3'd4, CTL_BRZ = 3'd5, CTL_BRC = 3'd6
    } ctl_e;

    typedef struct packed {
        src_e src;
        dst_e dst;
        ctl_e ctl;
    } uword_t;

    // Shared operand fetch of classes 3..5: PC->MAR, MEM->B with CE
    function automatic uword_t operand_fetch(input int st);
        uword_t w;
        w = '{SRC_NONE, DST_NONE, CTL_NONE};
        if (st == 2) w = '{SRC_PC, DST_MAR, CTL_NONE};
        if (st == 3) w = '{SRC_MEM, DST_B, CTL_CE};
        return w;
    endfunction

    // Microcode store contents, addressed by {class, step}
    function automatic uword_t ucode(input logic [P_CLS_W-1:0] cls,
                                     input logic [P_STEP_W-1:0] step);
        uword_t w;
        int st;
        st = int'(step);
        w  = '{SRC_NONE, DST_NONE, CTL_NONE};
        if (st == 0) begin
            w = '{SRC_PC, DST_MAR, CTL_NONE};
        end else if (st == 1) begin
            w = '{SRC_MEM, DST_IR, CTL_CE};
        end else begin
            case (int'(cls))
                0: if (st == 2) w.ctl = CTL_END;
                1: case (st)
                       2: w = '{SRC_PC,  DST_MAR, CTL_NONE};
                       3: w = '{SRC_MEM, DST_B,   CTL_CE};
                       4: w = '{SRC_SUM, DST_TMP, CTL_FLAGS};
                       5: w = '{SRC_TMP, DST_ACC, CTL_END};
                       default: ;
                   endcase
                2: case (st)
                       2: w = '{SRC_PC,  DST_MAR, CTL_NONE};
                       3: w = '{SRC_MEM, DST_ACC, CTL_CE};
                       4: w = '{SRC_NONE, DST_NONE, CTL_END};
                       default: ;
                   endcase
                3, 4, 5: begin
                    w = operand_fetch(st);
                    if (st == 4)
                        w.ctl = (cls == P_CLS_W'(3)) ? CTL_SUMPC :
                                (cls == P_CLS_W'(4)) ? CTL_BRZ : CTL_BRC;
                    if (st == 5) w.ctl = CTL_END;
                end
                6: if (st == 2) w = '{SRC_ACC, DST_OUT, CTL_END};
                7: case (st)
                       2: w = '{SRC_ACC, DST_TMP, CTL_NONE};
                       3: w = '{SRC_TMP, DST_B,   CTL_END};
                       default: ;
                   endcase
                default: ;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/ctl_step_ctr.sv
module ctl_step_ctr #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              end_i,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] LAST = {STEP_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || end_i) step <= '0;
        else              step <= step + 1'b1;
    end

    // R1
    reset_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> step == '0);
    // R7
    early_end_chk: assert property (@(posedge clk) disable iff (rst)
        end_i |=> step == '0);
    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!end_i && step == LAST) |=> step == '0);
endmodule

// File: rtl/ctl_ucode_rom.sv
module ctl_ucode_rom
    import ctl_pkg::*;
#(
    parameter int CLS_W  = P_CLS_W,
    parameter int STEP_W = P_STEP_W
) (
    input  logic [CLS_W-1:0]  cls,
    input  logic [STEP_W-1:0] step,
    output uword_t            word
);
    always_comb word = ucode(cls, step);
endmodule

// File: rtl/ctl_field_dec.sv
module ctl_field_dec #(
    parameter int W = 3,
    parameter int N = 7
) (
    input  logic [W-1:0] code,
    output logic [N-1:0] en
);
    // code 0 means no enable; code k drives en[k-1]
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign en[i] = (code == W'(i + 1));
    end
endmodule

// File: rtl/ctl_unit.sv
module ctl_unit
    import ctl_pkg::*;
#(
    parameter int OPC_W  = P_OPC_W,
    parameter int STEP_W = P_STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  ir,
    input  logic [1:0]        flags,
    output logic [STEP_W-1:0] step_o,
    output logic [N_SRC-1:0]  src_en,
    output logic [N_DST-1:0]  dst_en,
    output logic              ce,
    output logic              sum_pc,
    output logic              flags_ld,
    output logic              alu_inv
);
    localparam int CLS_W   = OPC_W - 2;
    localparam int SRC_RAW = N_SRC - 1;
    localparam int DST_RAW = N_DST - 1;
    localparam int CTL_RAW = 6;

    logic [STEP_W-1:0]  step;
    uword_t             uw;
    logic [SRC_RAW-1:0] src_raw;
    logic [DST_RAW-1:0] dst_raw;
    logic [CTL_RAW-1:0] ctl_raw;
    logic               swap;

    assign swap = ir[OPC_W-1];

    ctl_step_ctr #(.STEP_W(STEP_W)) u_ctr (
        .clk(clk), .rst(rst), .end_i(ctl_raw[3]), .step(step)
    );

    ctl_ucode_rom #(.CLS_W(CLS_W), .STEP_W(STEP_W)) u_rom (
        .cls(ir[OPC_W-2:1]), .step(step), .word(uw)
    );

    ctl_field_dec #(.W(P_CODE_W), .N(SRC_RAW)) u_src_dec (
        .code(uw.src), .en(src_raw)
    );
    ctl_field_dec #(.W(P_CODE_W), .N(DST_RAW)) u_dst_dec (
        .code(uw.dst), .en(dst_raw)
    );
    ctl_field_dec #(.W(P_CODE_W), .N(CTL_RAW)) u_ctl_dec (
        .code(uw.ctl), .en(ctl_raw)
    );

    // accumulator reference steered to A or C by the swap bit
    assign src_en = {src_raw[5], src_raw[4], src_raw[3], src_raw[2],
                     src_raw[0] & swap, src_raw[1], src_raw[0] & ~swap};
    assign dst_en = {dst_raw[6], dst_raw[5], dst_raw[4], dst_raw[3], dst_raw[2],
                     dst_raw[0] & swap, dst_raw[1], dst_raw[0] & ~swap};

    assign ce       = ctl_raw[0];
    assign flags_ld = ctl_raw[2];
    assign sum_pc   = ctl_raw[1] | (ctl_raw[4] & flags[0]) | (ctl_raw[5] & flags[1]);
    assign alu_inv  = ir[0];
    assign step_o   = step;

    // R3
    src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_en));
    // R4
    dst_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dst_en));
    // R5
    swap_c_chk: assert property (@(posedge clk) disable iff (rst)
        swap |-> !src_en[0] && !dst_en[0]);
    // R5
    swap_a_chk: assert property (@(posedge clk) disable iff (rst)
        !swap |-> !src_en[2] && !dst_en[2]);
    // R2
    fetch_ir_chk: assert property (@(posedge clk) disable iff (rst)
        step == STEP_W'(1) |-> ce && dst_en[6] && src_en[5]);
    // R9
    ce_sumpc_chk: assert property (@(posedge clk) disable iff (rst)
        !(ce && sum_pc));
endmodule

// File: tb/ctl_unit_bench.sv
`timescale 1ns/1ps
module ctl_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ir = 8'h00;
    logic [1:0] flags = 2'b00;
    logic [3:0] step_o;
    logic [6:0] src_en;
    logic [7:0] dst_en;
    logic       ce, sum_pc, flags_ld, alu_inv;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] exp_step = 4'd0;

    always #2.5 clk = ~clk;

    ctl_unit u_ctl_unit (
        .clk(clk), .rst(rst), .ir(ir), .flags(flags), .step_o(step_o),
        .src_en(src_en), .dst_en(dst_en), .ce(ce), .sum_pc(sum_pc),
        .flags_ld(flags_ld), .alu_inv(alu_inv)
    );

    // expected {src,dst,ctl} codes per requirements R1,R2,R8,R10..R12
    // src: 1 ACC 2 B 3 T 4 PC 5 MEM 6 SUM; dst: 1 ACC 2 B 3 T 4 MAR 5 MEM 6 IR 7 OUT
    // ctl: 1 CE 2 JUMP 3 FLAGS 4 END 5 BRZ 6 BRC
    function automatic logic [8:0] ref_word(input int cls, input int st);
        if (st == 0) return {3'd4, 3'd4, 3'd0};
        if (st == 1) return {3'd5, 3'd6, 3'd1};
        if (cls == 0) return (st == 2) ? {3'd0, 3'd0, 3'd4} : 9'd0;
        if (cls == 1 || cls == 2 || (cls >= 3 && cls <= 5)) begin
            if (st == 2) return {3'd4, 3'd4, 3'd0};
            if (st == 3) return (cls == 2) ? {3'd5, 3'd1, 3'd1} : {3'd5, 3'd2, 3'd1};
        end
        if (cls == 1 && st == 4) return {3'd6, 3'd3, 3'd3};
        if (cls == 1 && st == 5) return {3'd3, 3'd1, 3'd4};
        if (cls == 2 && st == 4) return {3'd0, 3'd0, 3'd4};
        if (cls >= 3 && cls <= 5 && st == 4)
            return {3'd0, 3'd0, (cls == 3) ? 3'd2 : (cls == 4) ? 3'd5 : 3'd6};
        if (cls >= 3 && cls <= 5 && st == 5) return {3'd0, 3'd0, 3'd4};
        if (cls == 6 && st == 2) return {3'd1, 3'd7, 3'd4};
        if (cls == 7 && st == 2) return {3'd1, 3'd3, 3'd0};
        if (cls == 7 && st == 3) return {3'd3, 3'd2, 3'd4};
        return 9'd0;
    endfunction

    function automatic logic [6:0] ref_src(input logic [2:0] c, input logic sw);
        case (c)
            3'd1: return sw ? 7'b0000100 : 7'b0000001;
            3'd2: return 7'b0000010;
            3'd3: return 7'b0001000;
            3'd4: return 7'b0010000;
            3'd5: return 7'b0100000;
            3'd6: return 7'b1000000;
            default: return 7'd0;
        endcase
    endfunction

    function automatic logic [7:0] ref_dst(input logic [2:0] c, input logic sw);
        case (c)
            3'd1: return sw ? 8'b00000100 : 8'b00000001;
            3'd2: return 8'b00000010;
            3'd3: return 8'b00001000;
            3'd4: return 8'b00010000;
            3'd5: return 8'b00100000;
            3'd6: return 8'b01000000;
            3'd7: return 8'b10000000;
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s op=%02h step=%0d actual=%0h expected=%0h",
                     tag, ir, exp_step, act, expv);
        end
    endtask

    // one cycle: drive at negedge, check just after, advance expected step
    task automatic cyc(input logic [7:0] op, input logic [1:0] fl);
        logic [8:0] w;
        logic [2:0] cc;
        logic e_sum;
        @(negedge clk);
        rst = 1'b0; ir = op; flags = fl;
        #1;
        w = ref_word(int'(op[6:1]), int'(exp_step));
        cc = w[2:0];
        e_sum = (cc == 3'd2) || (cc == 3'd5 && fl[0]) || (cc == 3'd6 && fl[1]);
        chk(step_o == exp_step, "R7 R8 step", 32'(step_o), 32'(exp_step));
        chk(src_en == ref_src(w[8:6], op[7]), "R3 R5 src_en", 32'(src_en),
            32'(ref_src(w[8:6], op[7])));
        chk(dst_en == ref_dst(w[5:3], op[7]), "R4 R5 dst_en", 32'(dst_en),
            32'(ref_dst(w[5:3], op[7])));
        chk(ce == (cc == 3'd1), "R2 R10 ce", 32'(ce), 32'(cc == 3'd1));
        chk(sum_pc == e_sum, "R9 sum_pc", 32'(sum_pc), 32'(e_sum));
        chk(flags_ld == (cc == 3'd3), "R10 flags_ld", 32'(flags_ld), 32'(cc == 3'd3));
        chk(alu_inv == op[0], "R6 alu_inv", 32'(alu_inv), 32'(op[0]));
        exp_step = (cc == 3'd4) ? 4'd0 : exp_step + 4'd1;
    endtask

    task automatic run_instr(input logic [7:0] op, input logic [1:0] fl);
        cyc(op, fl);
        for (int k = 0; k < 16 && exp_step != 4'd0; k++) cyc(op, fl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        exp_step = 4'd0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] op;
        void'($urandom(32'd7741));
        do_reset();
        // R1: state right after reset is fetch step 0
        cyc(8'h00, 2'b00);
        chk(exp_step == 4'd1, "R1 advance", 32'(exp_step), 32'd1);
        do_reset();
        // R12 class 0 ends at step 2
        run_instr(8'h00, 2'b00);
        // R10 R7 ALU add/sub, with and without swap (end and load in same step)
        run_instr(8'h02, 2'b00);
        run_instr(8'h03, 2'b00);
        run_instr(8'h82, 2'b11);
        run_instr(8'h83, 2'b01);
        run_instr(8'h84, 2'b00);
        // R11 R9 branches taken and not taken
        run_instr(8'h06, 2'b00);
        run_instr(8'h08, 2'b00);
        run_instr(8'h08, 2'b01);
        run_instr(8'h0A, 2'b01);
        run_instr(8'h0A, 2'b10);
        // R12 output and move, swapped
        run_instr(8'h8C, 2'b00);
        run_instr(8'h0E, 2'b00);
        run_instr(8'h8F, 2'b00);
        // R8 idle class runs 16 steps then wraps into fetch
        run_instr(8'h10, 2'b00);
        chk(exp_step == 4'd0, "R8 wrap", 32'(exp_step), 32'd0);
        cyc(8'h10, 2'b00);
        // R1 reset in the middle of an instruction
        cyc(8'h02, 2'b00);
        cyc(8'h02, 2'b00);
        do_reset();
        cyc(8'h02, 2'b00);
        run_instr(8'h02, 2'b00);
        // random opcodes, biased toward defined classes, random flags
        for (int n = 0; n < 400; n++) begin
            op = 8'($urandom);
            if (($urandom % 4) != 0) op[6:4] = 3'b000;
            cyc(op, 2'($urandom));
            for (int k = 0; k < 16 && exp_step != 4'd0; k++) cyc(op, 2'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule